// File: doc/BRIEF.md
# Dual-Port Mailbox With Byte Flags

This block lets two independent register-access ports, a host side and a local side, pass 32-bit words to each other through a set of small mailboxes. Each side owns four outgoing mailboxes that it writes and may read back. The same storage appears on the opposite side as four read-only incoming mailboxes. Every byte that can be passed has a full/empty flag. Both sides see the same flag state, each through its own read-only status register.

A write to an outgoing byte marks that byte full. A read of that byte from the receiving side marks it empty again. Either side can also clear every flag at once by writing a one to a write-only control bit. Software on each side polls its status word to find bytes that are waiting to be read, and to find bytes whose previous contents the peer has already read.

Top module: `mbox_xchg`

## Requirements
- R1: Each side decodes its address as follows: 0 to 3 are its own outgoing mailboxes, 4 to 7 are its incoming mailboxes 0 to 3, 8 is its status word and 9 is its flag-reset control. A read returns data on rdata in the cycle after rd is sampled. That data is the content as it stood before that cycle's updates, and rdata holds its value until the next read. Reads of address 9 return zero.
- R2: A write to an outgoing mailbox stores only the byte lanes whose byte-enable bit is set, where lane b is data bits 8b+7:8b. The owner reads back the stored word.
- R3: An incoming mailbox returns the peer's outgoing mailbox with the same index. Writes to incoming mailboxes change neither the data nor the flags.
- R4: A write sets the flag of each enabled byte. Flag numbering is as follows. In host status, bit 4*box+lane is host outgoing byte (box, lane) and bit 16+4*box+lane is host incoming byte (box, lane). Local status uses the same layout, with bits 15:0 for local outgoing bytes and bits 31:16 for local incoming bytes.
- R5: A read of an incoming mailbox clears the flags of the enabled lanes, as seen in both status views. The flags of unselected lanes are unchanged. An owner reading back its own outgoing mailbox clears no flag.
- R6: Writing to a byte that is still full replaces the unread data, and its flag stays set.
- R7: Writes to either status word leave all flags unchanged.
- R8: A write to the control address with byte enable 0 set and data bit 0 equal to one clears all 32 flags by the next cycle. With data bit 0 equal to zero, the write has no effect.
- R9: When a write that sets a flag and a peer read that clears the same flag occur in the same cycle, the flag ends up set.
- R10: A flag-reset write from either side overrides any flag set or clear in the same cycle. Data written in that cycle is still stored.
- R11: After system reset, all flags are zero and both rdata outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 4 | Host register address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after the read |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe |
| l_addr | input | 4 | Local register address |
| l_be | input | 4 | Local byte enables |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, one cycle after the read |

## Verification
The flag properties assume that the set, clear and reset masks derived from the port decode are the only causes of flag change. They also assume that a side asserts rd only when it wants rdata to be replaced. The stimulus uses one-cycle strobes on addresses 0 to 9 only. Before partial-lane writes are used, it fills every mailbox word with a full write, so that every later read returns defined bytes. Cycles in which both sides act at once are limited to the deliberate write-against-read and write-against-reset cases.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_OUT,
    RG_IN,
    RG_STAT,
    RG_CTRL
  } rgn_e;
endpackage

// File: rtl/mbox_bank.sv
// Byte-writable mailbox storage: owner port A (write + read), peer port B (read).
module mbox_bank #(
  parameter int NB = 4,
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [IW-1:0]     a_idx,
  input  logic [DW/8-1:0]   a_be,
  input  logic [DW-1:0]     a_wdata,
  output logic [DW-1:0]     a_rdata,
  input  logic              b_re,
  input  logic [IW-1:0]     b_idx,
  output logic [DW-1:0]     b_rdata
);
  localparam int BW = DW / 8;

  logic [DW-1:0] mem [NB];

  always_ff @(posedge clk) begin
    if (a_we) begin
      for (int b = 0; b < BW; b++) begin
        if (a_be[b]) mem[a_idx][b*8 +: 8] <= a_wdata[b*8 +: 8];
      end
    end
    if (a_re) a_rdata <= mem[a_idx];
    if (b_re) b_rdata <= mem[b_idx];
  end
endmodule

// File: rtl/mbox_flags.sv
// Shared byte flags. Priority: flag reset, then set, then clear.
module mbox_flags #(
  parameter int NF = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wipe,
  input  logic [NF-1:0] h_set,
  input  logic [NF-1:0] l_clr,
  input  logic [NF-1:0] l_set,
  input  logic [NF-1:0] h_clr,
  output logic [NF-1:0] h2l,
  output logic [NF-1:0] l2h
);
  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      h2l <= '0;
      l2h <= '0;
    end else begin
      h2l <= h_set | (h2l & ~l_clr);
      l2h <= l_set | (l2h & ~h_clr);
    end
  end
endmodule

// File: rtl/mbox_port.sv
// One side's register decode and read-data path.
module mbox_port
  import mbox_pkg::*;
#(
  parameter int NB = 4,
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int IW = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [AW-1:0]          addr,
  input  logic [DW/8-1:0]        be,
  input  logic                   ctrl_bit,
  input  logic [DW-1:0]          own_rdata,
  input  logic [DW-1:0]          peer_rdata,
  input  logic [DW-1:0]          status,
  output logic                   own_we,
  output logic                   own_re,
  output logic [IW-1:0]          own_idx,
  output logic                   peer_re,
  output logic [IW-1:0]          peer_idx,
  output logic [NB*(DW/8)-1:0]   set_mask,
  output logic [NB*(DW/8)-1:0]   clr_mask,
  output logic                   flag_rst,
  output logic [DW-1:0]          rdata
);
  localparam int BW = DW / 8;
  localparam logic [AW-1:0] A_IN   = AW'(NB);
  localparam logic [AW-1:0] A_STAT = AW'(2 * NB);
  localparam logic [AW-1:0] A_CTRL = AW'(2 * NB + 1);

  rgn_e          rgn;
  rgn_e          sel_q;
  logic [DW-1:0] stat_q;

  always_comb begin
    if (addr < A_IN)        rgn = RG_OUT;
    else if (addr < A_STAT) rgn = RG_IN;
    else if (addr == A_STAT) rgn = RG_STAT;
    else if (addr == A_CTRL) rgn = RG_CTRL;
    else                    rgn = RG_NONE;
  end

  assign own_we   = wr && (rgn == RG_OUT);
  assign own_re   = rd && (rgn == RG_OUT);
  assign peer_re  = rd && (rgn == RG_IN);
  assign own_idx  = IW'(addr);
  assign peer_idx = IW'(addr - A_IN);
  assign flag_rst = wr && (rgn == RG_CTRL) && be[0] && ctrl_bit;

  for (genvar i = 0; i < NB; i++) begin : g_box
    for (genvar b = 0; b < BW; b++) begin : g_lane
      assign set_mask[i*BW+b] = wr && (addr == AW'(i)) && be[b];
      assign clr_mask[i*BW+b] = rd && (addr == AW'(NB + i)) && be[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= RG_NONE;
      stat_q <= '0;
    end else if (rd) begin
      sel_q <= rgn;
      if (rgn == RG_STAT) stat_q <= status;
    end
  end

  always_comb begin
    case (sel_q)
      RG_OUT:  rdata = own_rdata;
      RG_IN:   rdata = peer_rdata;
      RG_STAT: rdata = stat_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbox_xchg.sv
module mbox_xchg #(
  parameter int NB = 4,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            h_wr,
  input  logic            h_rd,
  input  logic [AW-1:0]   h_addr,
  input  logic [DW/8-1:0] h_be,
  input  logic [DW-1:0]   h_wdata,
  output logic [DW-1:0]   h_rdata,
  input  logic            l_wr,
  input  logic            l_rd,
  input  logic [AW-1:0]   l_addr,
  input  logic [DW/8-1:0] l_be,
  input  logic [DW-1:0]   l_wdata,
  output logic [DW-1:0]   l_rdata
);
  localparam int BW = DW / 8;
  localparam int NF = NB * BW;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic          h_we, h_re, hp_re, l_we, l_re, lp_re;
  logic [IW-1:0] h_idx, hp_idx, l_idx, lp_idx;
  logic [NF-1:0] h_set, h_clr, l_set, l_clr;
  logic          h_frst, l_frst;
  logic [NF-1:0] h2l_flags, l2h_flags;
  logic [DW-1:0] hb_a, hb_b, lb_a, lb_b;
  logic [DW-1:0] h_stat, l_stat;

  assign h_stat = DW'({l2h_flags, h2l_flags});
  assign l_stat = DW'({h2l_flags, l2h_flags});

  mbox_port #(.NB(NB), .DW(DW), .AW(AW), .IW(IW)) u_hport (
    .clk(clk), .rst(rst), .wr(h_wr), .rd(h_rd), .addr(h_addr), .be(h_be),
    .ctrl_bit(h_wdata[0]), .own_rdata(hb_a), .peer_rdata(lb_b), .status(h_stat),
    .own_we(h_we), .own_re(h_re), .own_idx(h_idx), .peer_re(hp_re), .peer_idx(hp_idx),
    .set_mask(h_set), .clr_mask(h_clr), .flag_rst(h_frst), .rdata(h_rdata)
  );

  mbox_port #(.NB(NB), .DW(DW), .AW(AW), .IW(IW)) u_lport (
    .clk(clk), .rst(rst), .wr(l_wr), .rd(l_rd), .addr(l_addr), .be(l_be),
    .ctrl_bit(l_wdata[0]), .own_rdata(lb_a), .peer_rdata(hb_b), .status(l_stat),
    .own_we(l_we), .own_re(l_re), .own_idx(l_idx), .peer_re(lp_re), .peer_idx(lp_idx),
    .set_mask(l_set), .clr_mask(l_clr), .flag_rst(l_frst), .rdata(l_rdata)
  );

  mbox_bank #(.NB(NB), .DW(DW), .IW(IW)) u_hbank (
    .clk(clk), .a_we(h_we), .a_re(h_re), .a_idx(h_idx), .a_be(h_be),
    .a_wdata(h_wdata), .a_rdata(hb_a), .b_re(lp_re), .b_idx(lp_idx), .b_rdata(hb_b)
  );

  mbox_bank #(.NB(NB), .DW(DW), .IW(IW)) u_lbank (
    .clk(clk), .a_we(l_we), .a_re(l_re), .a_idx(l_idx), .a_be(l_be),
    .a_wdata(l_wdata), .a_rdata(lb_a), .b_re(hp_re), .b_idx(hp_idx), .b_rdata(lb_b)
  );

  mbox_flags #(.NF(NF)) u_flags (
    .clk(clk), .rst(rst), .wipe(h_frst || l_frst),
    .h_set(h_set), .l_clr(l_clr), .l_set(l_set), .h_clr(h_clr),
    .h2l(h2l_flags), .l2h(l2h_flags)
  );
endmodule

// File: rtl/mbox_xchg_chk.sv
module mbox_xchg_chk #(
  parameter int NF = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          h_rd,
  input logic          l_rd,
  input logic [DW-1:0] h_rdata,
  input logic [DW-1:0] l_rdata,
  input logic [NF-1:0] h_set,
  input logic [NF-1:0] h_clr,
  input logic [NF-1:0] l_set,
  input logic [NF-1:0] l_clr,
  input logic          h_frst,
  input logic          l_frst,
  input logic [NF-1:0] h2l_flags,
  input logic [NF-1:0] l2h_flags
);
  logic wipe;
  assign wipe = h_frst || l_frst;

  // R10
  wipe_all_chk: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (h2l_flags == '0 && l2h_flags == '0));

  // R4
  set_h2l_chk: assert property (@(posedge clk) disable iff (rst)
    !wipe |=> ((h2l_flags & $past(h_set)) == $past(h_set)));

  // R4
  set_l2h_chk: assert property (@(posedge clk) disable iff (rst)
    !wipe |=> ((l2h_flags & $past(l_set)) == $past(l_set)));

  // R5
  clr_h2l_chk: assert property (@(posedge clk) disable iff (rst)
    !wipe |=> ((h2l_flags & $past(l_clr & ~h_set)) == '0));

  // R5
  clr_l2h_chk: assert property (@(posedge clk) disable iff (rst)
    !wipe |=> ((l2h_flags & $past(h_clr & ~l_set)) == '0));

  // R9
  race_win_chk: assert property (@(posedge clk) disable iff (rst)
    (!wipe && (h_set & l_clr) != '0) |=> ((h2l_flags & $past(h_set & l_clr)) != '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wipe && h_set == '0 && l_set == '0 && h_clr == '0 && l_clr == '0)
      |=> ($stable(h2l_flags) && $stable(l2h_flags)));

  // R1
  h_rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !h_rd |=> $stable(h_rdata));

  // R1
  l_rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !l_rd |=> $stable(l_rdata));
endmodule

bind mbox_xchg mbox_xchg_chk #(.NF(NF), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .h_rd(h_rd), .l_rd(l_rd), .h_rdata(h_rdata), .l_rdata(l_rdata),
  .h_set(h_set), .h_clr(h_clr), .l_set(l_set), .l_clr(l_clr),
  .h_frst(h_frst), .l_frst(l_frst), .h2l_flags(h2l_flags), .l2h_flags(l2h_flags)
);

// File: tb/mbox_xchg_test.sv
module mbox_xchg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_wr = 0, h_rd = 0, l_wr = 0, l_rd = 0;
  logic [3:0]  h_addr = 0, l_addr = 0, h_be = 0, l_be = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0;
  logic [31:0] h_rdata, l_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_box [2][4];
  logic [15:0] m_flag [2];

  always #4 clk = ~clk;

  mbox_xchg uut (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_be(l_be), .l_wdata(l_wdata), .l_rdata(l_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drv_wr(input int s, input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    if (s == 0) begin h_wr = 1; h_addr = a; h_be = be; h_wdata = d; end
    else        begin l_wr = 1; l_addr = a; l_be = be; l_wdata = d; end
  endtask

  task automatic drv_rd(input int s, input logic [3:0] a, input logic [3:0] be);
    if (s == 0) begin h_rd = 1; h_addr = a; h_be = be; end
    else        begin l_rd = 1; l_addr = a; l_be = be; end
  endtask

  task automatic idle;
    @(negedge clk);
    h_wr = 0; h_rd = 0; l_wr = 0; l_rd = 0;
  endtask

  task automatic do_read(input int s, input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
    drv_rd(s, a, be);
    idle();
    d = (s == 0) ? h_rdata : l_rdata;
  endtask

  task automatic m_write(input int s, input int box, input logic [3:0] be, input logic [31:0] d);
    drv_wr(s, 4'(box), be, d);
    idle();
    for (int b = 0; b < 4; b++) begin
      if (be[b]) begin
        m_box[s][box][b*8 +: 8] = d[b*8 +: 8];
        m_flag[s][box*4+b] = 1'b1;
      end
    end
  endtask

  task automatic m_read_in(input int r, input int box, input logic [3:0] be, input string tag);
    logic [31:0] got;
    do_read(r, 4'(4 + box), be, got);
    chk(tag, got, m_box[1-r][box]);
    for (int b = 0; b < 4; b++) if (be[b]) m_flag[1-r][box*4+b] = 1'b0;
  endtask

  task automatic chk_own(input int s, input int box, input string tag);
    logic [31:0] got;
    do_read(s, 4'(box), 4'hF, got);
    chk(tag, got, m_box[s][box]);
  endtask

  task automatic chk_stat(input int r, input string tag);
    logic [31:0] got;
    do_read(r, 4'd8, 4'hF, got);
    chk(tag, got, {m_flag[1-r], m_flag[r]});
  endtask

  initial begin
    logic [31:0] got;
    logic [31:0] d;
    logic [3:0]  rbe;
    m_flag[0] = '0;
    m_flag[1] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11: outputs and flags after reset
    chk("R11 host rdata", h_rdata, 32'h0);
    chk("R11 local rdata", l_rdata, 32'h0);
    chk_stat(0, "R11 host status");
    chk_stat(1, "R11 local status");

    // Fill all boxes, then flag reset (R8)
    for (int s = 0; s < 2; s++)
      for (int box = 0; box < 4; box++)
        m_write(s, box, 4'hF, 32'h1111_1111 * (s * 4 + box + 1));
    chk_stat(0, "R4 full fill host status");
    drv_wr(0, 4'd9, 4'h1, 32'h1);
    idle();
    m_flag[0] = '0; m_flag[1] = '0;
    chk_stat(0, "R8 host wipe");
    chk_stat(1, "R8 host wipe local view");
    do_read(0, 4'd9, 4'hF, got);
    chk("R1 control reads zero", got, 32'h0);

    // Sweep all sides, boxes and byte-enable patterns
    for (int s = 0; s < 2; s++) begin
      for (int box = 0; box < 4; box++) begin
        for (int be = 1; be < 16; be++) begin
          d = (32'hC3A5_5A3C >> s) ^ (32'(box) << 20) ^ (32'(be) * 32'h0107_0B0D);
          m_write(s, box, 4'(be), d);
          chk_stat(s, "R4 writer status");
          chk_stat(1 - s, "R4 peer status");
          chk_own(s, box, "R2 owner readback");
          chk_stat(s, "R5 owner readback keeps flags");
          rbe = 4'((be + box + 1) & 15);
          m_read_in(1 - s, box, rbe, "R3 incoming data");
          chk_stat(1 - s, "R5 reader status");
          chk_stat(s, "R5 writer status");
        end
      end
    end

    // R6: overwrite of an unread byte
    m_write(0, 2, 4'hF, 32'hAAAA_0001);
    m_write(0, 2, 4'h6, 32'hBBBB_BBBB);
    chk_stat(1, "R6 flags stay full");
    m_read_in(1, 2, 4'hF, "R6 overwritten data");
    chk_stat(0, "R6 flags after read");

    // R7: status writes ignored
    m_write(1, 1, 4'h5, 32'h0F0F_0F0F);
    drv_wr(0, 4'd8, 4'hF, 32'hFFFF_FFFF);
    idle();
    drv_wr(1, 4'd8, 4'hF, 32'h0000_0000);
    idle();
    chk_stat(0, "R7 host status after status writes");
    chk_stat(1, "R7 local status after status writes");

    // R3: writes to an incoming mailbox ignored
    drv_wr(1, 4'd5, 4'hF, 32'hDEAD_BEEF);
    idle();
    chk_own(0, 1, "R3 incoming write leaves peer data");
    chk_stat(0, "R3 incoming write leaves flags");

    // R8: writing zero to control does nothing
    drv_wr(1, 4'd9, 4'hF, 32'hFFFF_FFFE);
    idle();
    chk_stat(0, "R8 zero write keeps flags");
    drv_wr(1, 4'd9, 4'h1, 32'h1);
    idle();
    m_flag[0] = '0; m_flag[1] = '0;
    chk_stat(0, "R8 local wipe host view");
    chk_stat(1, "R8 local wipe local view");

    // R9: write and peer read of same byte in one cycle
    d = m_box[0][0];
    drv_wr(0, 4'd0, 4'h1, 32'h0000_0077);
    drv_rd(1, 4'd4, 4'h1);
    idle();
    chk("R9 concurrent read sees old data", l_rdata, d);
    m_box[0][0][7:0] = 8'h77;
    m_flag[0][0] = 1'b1;
    chk_stat(1, "R9 write wins flag");
    chk_own(0, 0, "R9 data stored");

    // R10: wipe beats set in the same cycle
    drv_wr(0, 4'd3, 4'hF, 32'h3C3C_3C3C);
    drv_wr(1, 4'd9, 4'h1, 32'h1);
    idle();
    m_box[0][3] = 32'h3C3C_3C3C;
    m_flag[0] = '0; m_flag[1] = '0;
    chk_stat(0, "R10 wipe beats set host");
    chk_stat(1, "R10 wipe beats set local");
    chk_own(0, 3, "R10 data still stored");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule